// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between an 8-bit microcontroller core and its external memories. The core hands it one request at a time: a code fetch, a data read or a data write. A data request names one of two pointer widths. A 16-bit pointer reaches a 64 KB space. An 8-bit pointer reaches a 256-byte page. The block runs the bus cycle and, for reads, returns the byte it sampled.

The bus has two parts. A shared byte-wide port first carries the low address byte, which an external latch captures while the address-latch strobe is high. The same port then carries the data byte. A second port carries the high address byte for the whole access. It is left undriven for 8-bit-pointer accesses, so that port stays free as general I/O. Code reads use their own strobe. Data reads and data writes each have a separate strobe. All three strobes are active low.

When the internal-ROM enable input is high, code fetches below `INT_ROM_BYTES` touch no pin. The block only acknowledges them on a separate pulse.

The sequencer has seven states:
- IDLE: no access in progress.
- ADDR: address driven, latch strobe high.
- HOLD: address held, latch strobe low.
- SETUP: turnaround for a read, or write data put on the port.
- STRB_A and STRB_B: the active strobe is low.
- RECOV: all strobes high.

Transitions:
- IDLE goes to ADDR on an accepted external request and otherwise stays in IDLE.
- ADDR, HOLD, SETUP, STRB_A and STRB_B always advance one step, in that order, ending in RECOV.
- RECOV goes to ADDR when a new external request is accepted, and otherwise to IDLE.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, and at once whenever reset is asserted (even mid-access): `ale` is 0, `code_rd_n`, `rd_n` and `wr_n` are 1, `ad_oe` and `hi_oe` are 0, `done` and `int_hit` are 0. In IDLE, `req_ready` is 1.
- R2: An external access starts, on the edge that accepts it, with one clock in which `ale`=1, `ad_oe`=1 and `ad_out`=address[7:0]. It is followed by one clock with `ale`=0 and the same address still driven.
- R3: For code fetches, and for data accesses with `req_narrow`=0, `hi_oe`=1 and `hi_out`=address[15:8] from the `ale` clock through the recovery clock.
- R4: A data access with `req_narrow`=1 never sets `hi_oe`.
- R5: A code fetch (`req_op`=0) holds `code_rd_n` low for two clocks, starting three clocks after the `ale` clock. `rdata` takes `ad_in` as it stands in the last low clock.
- R6: A data read (`req_op`=1) uses `rd_n` with the same timing and capture as R5.
- R7: A data write (`req_op`=2) drives `req_wdata` on `ad_out` with `ad_oe`=1 from the clock after the address hold through the recovery clock. `wr_n` is low for the two clocks in the middle of that window.
- R8: At most one of `code_rd_n`, `rd_n` and `wr_n` is low at a time. `ad_oe` is 0 whenever `code_rd_n` or `rd_n` is low.
- R9: `done` is a one-clock pulse in the clock after the strobe has returned high, which is two clocks after the last strobe-low clock.
- R10: `req_ready` is 1 in IDLE and RECOV. With requests offered back to back, `ale` rises every 6 clocks.
- R11: With `int_rom_en`=1, a code fetch to an address below `INT_ROM_BYTES` (4096) makes no `ale`, strobe, `ad_oe` or `hi_oe` activity, and pulses `int_hit` in the next clock. Address 4096 and above goes external. With `int_rom_en`=0, every code fetch goes external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_op | input | 2 | 0 code fetch, 1 data read, 2 data write |
| req_narrow | input | 1 | Data access uses an 8-bit pointer |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| int_rom_en | input | 1 | Low code page served internally |
| req_ready | output | 1 | Request accepted on this edge if valid |
| rdata | output | 8 | Byte returned by the last read |
| done | output | 1 | External access complete |
| int_hit | output | 1 | Code fetch served internally |
| ad_out | output | 8 | Shared port, driven value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port, sampled value |
| hi_out | output | 8 | High address port value |
| hi_oe | output | 1 | High address port output enable |
| ale | output | 1 | Address latch strobe |
| code_rd_n | output | 1 | Code read strobe |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Data write strobe |

## Verification
The hardest case to reach is the RECOV-to-ADDR path. It only occurs when a new request is already waiting in the recovery clock. The stimulus holds `req_valid` high over three reads and measures the spacing of the `ale` pulses. The second hard case is a reset that lands while `wr_n` is low. The bench waits for the write strobe and then drops reset, checking that every pin returns to idle at once. The internal-ROM boundary is hit with fetches at 4095 and 4096.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int XB_AW = 16;
    localparam int XB_DW = 8;
    localparam int XB_HW = XB_AW - XB_DW;

    typedef enum logic [1:0] {
        OP_CODE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } xb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ADDR   = 3'd1,
        ST_HOLD   = 3'd2,
        ST_SETUP  = 3'd3,
        ST_STRB_A = 3'd4,
        ST_STRB_B = 3'd5,
        ST_RECOV  = 3'd6
    } xb_state_e;

    typedef struct packed {
        xb_op_e            op;
        logic              narrow;
        logic [XB_AW-1:0]  addr;
        logic [XB_DW-1:0]  wdata;
    } xb_req_t;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  xb_op_e           req_op,
    input  logic [XB_AW-1:0] req_addr,
    input  logic             int_rom_en,
    output xb_state_e        state_q,
    output logic             accept_ext,
    output logic             accept_int,
    output logic             req_ready
);
    localparam logic [XB_AW:0] ROM_LIMIT = (XB_AW+1)'(INT_ROM_BYTES);

    xb_state_e state_d;
    logic      is_internal;

    always_comb begin
        req_ready   = (state_q == ST_IDLE) || (state_q == ST_RECOV);
        is_internal = int_rom_en && (req_op == OP_CODE) &&
                      ({1'b0, req_addr} < ROM_LIMIT);
        accept_int  = req_valid && req_ready && is_internal;
        accept_ext  = req_valid && req_ready && !is_internal &&
                      (req_op != OP_RSVD);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = accept_ext ? ST_ADDR : ST_IDLE;
            ST_ADDR:   state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STRB_A;
            ST_STRB_A: state_d = ST_STRB_B;
            ST_STRB_B: state_d = ST_RECOV;
            ST_RECOV:  state_d = accept_ext ? ST_ADDR : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/xbus_req_reg.sv
module xbus_req_reg
    import xbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  xb_req_t req_in,
    output xb_req_t req_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    req_q <= '0;
        else if (load) req_q <= req_in;
    end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
(
    input  xb_state_e        state_q,
    input  xb_req_t          req_q,
    output logic [XB_DW-1:0] ad_out,
    output logic             ad_oe,
    output logic [XB_HW-1:0] hi_out,
    output logic             hi_oe,
    output logic             ale,
    output logic             code_rd_n,
    output logic             rd_n,
    output logic             wr_n
);
    logic is_write;
    logic uses_hi;
    logic strobe_on;

    always_comb begin
        is_write  = (req_q.op == OP_WRITE);
        uses_hi   = (req_q.op == OP_CODE) || !req_q.narrow;
        strobe_on = 1'b0;
        ale       = 1'b0;
        ad_oe     = 1'b0;
        ad_out    = '0;
        code_rd_n = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = req_q.addr[XB_DW-1:0];
            end
            ST_HOLD: begin
                ad_oe  = 1'b1;
                ad_out = req_q.addr[XB_DW-1:0];
            end
            ST_SETUP, ST_RECOV: begin
                ad_oe  = is_write;
                ad_out = is_write ? req_q.wdata : '0;
            end
            ST_STRB_A, ST_STRB_B: begin
                strobe_on = 1'b1;
                ad_oe     = is_write;
                ad_out    = is_write ? req_q.wdata : '0;
            end
            default: begin
            end
        endcase
        if (strobe_on) begin
            code_rd_n = !(req_q.op == OP_CODE);
            rd_n      = !(req_q.op == OP_READ);
            wr_n      = !is_write;
        end
        hi_oe  = (state_q != ST_IDLE) && uses_hi;
        hi_out = hi_oe ? req_q.addr[XB_AW-1:XB_DW] : '0;
    end
endmodule

// File: rtl/xbus_return.sv
module xbus_return
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  xb_state_e        state_q,
    input  xb_op_e           op_q,
    input  logic             accept_int,
    input  logic [XB_DW-1:0] ad_in,
    output logic [XB_DW-1:0] rdata,
    output logic             done,
    output logic             int_hit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata   <= '0;
            done    <= 1'b0;
            int_hit <= 1'b0;
        end else begin
            if (state_q == ST_STRB_B && op_q != OP_WRITE) rdata <= ad_in;
            done    <= (state_q == ST_RECOV);
            int_hit <= accept_int;
        end
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_narrow,
    input  logic [XB_AW-1:0] req_addr,
    input  logic [XB_DW-1:0] req_wdata,
    input  logic             int_rom_en,
    output logic             req_ready,
    output logic [XB_DW-1:0] rdata,
    output logic             done,
    output logic             int_hit,
    output logic [XB_DW-1:0] ad_out,
    output logic             ad_oe,
    input  logic [XB_DW-1:0] ad_in,
    output logic [XB_HW-1:0] hi_out,
    output logic             hi_oe,
    output logic             ale,
    output logic             code_rd_n,
    output logic             rd_n,
    output logic             wr_n
);
    xb_state_e state_q;
    logic      accept_ext;
    logic      accept_int;
    xb_req_t   req_in;
    xb_req_t   req_q;

    always_comb begin
        req_in.op     = xb_op_e'(req_op);
        req_in.narrow = req_narrow;
        req_in.addr   = req_addr;
        req_in.wdata  = req_wdata;
    end

    xbus_seq #(.INT_ROM_BYTES(INT_ROM_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_in.op),
        .req_addr   (req_addr),
        .int_rom_en (int_rom_en),
        .state_q    (state_q),
        .accept_ext (accept_ext),
        .accept_int (accept_int),
        .req_ready  (req_ready)
    );

    xbus_req_reg u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept_ext),
        .req_in (req_in),
        .req_q  (req_q)
    );

    xbus_pins u_pins (
        .state_q   (state_q),
        .req_q     (req_q),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .hi_out    (hi_out),
        .hi_oe     (hi_oe),
        .ale       (ale),
        .code_rd_n (code_rd_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n)
    );

    xbus_return u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .op_q       (req_q.op),
        .accept_int (accept_int),
        .ad_in      (ad_in),
        .rdata      (rdata),
        .done       (done),
        .int_hit    (int_hit)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ad_out,
    input logic       ad_oe,
    input logic       ale,
    input logic       code_rd_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       done
);
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~code_rd_n, ~rd_n, ~wr_n}) <= 1);

    a_r8_float_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_rd_n || !rd_n) |-> !ad_oe);

    a_r2_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && $stable(ad_out)));

    a_r7_write_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && $stable(ad_out)));

    a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(code_rd_n & rd_n & wr_n) && !$past(code_rd_n & rd_n & wr_n, 2)));

    a_r10_ale_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> (!$past(ale, 2) && !$past(ale, 3) && !$past(ale, 4) && !$past(ale, 5)));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .code_rd_n (code_rd_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done)
);

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_narrow = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        int_rom_en = 1'b0;
    logic        req_ready, done, int_hit, ad_oe, hi_oe, ale, code_rd_n, rd_n, wr_n;
    logic [7:0]  rdata, ad_out, ad_in, hi_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] dmem [256];
    logic [7:0] lat_lo = 8'h0;
    int  ale_cnt, ale_cyc_last, ale_cyc_prev, last_low, done_cyc, int_cnt;
    int  bad_float = 0;
    int  bad_excl = 0;
    bit  hi_seen;
    logic [7:0] hi_val, wr_seen;

    // {op[1:0], narrow, rom_en, addr[15:0], wdata[7:0], expected read[7:0]}
    localparam int NV = 11;
    localparam logic [35:0] VECS [NV] = '{
        {2'd0, 1'b0, 1'b0, 16'h0123, 8'h00, 8'h00},
        {2'd0, 1'b0, 1'b1, 16'h0FFF, 8'h00, 8'h00},
        {2'd0, 1'b0, 1'b1, 16'h1000, 8'h00, 8'h00},
        {2'd0, 1'b0, 1'b0, 16'h0010, 8'h00, 8'h00},
        {2'd2, 1'b0, 1'b0, 16'hBE40, 8'h77, 8'h00},
        {2'd1, 1'b0, 1'b0, 16'hBE40, 8'h00, 8'h77},
        {2'd2, 1'b1, 1'b0, 16'hFF91, 8'hC3, 8'h00},
        {2'd1, 1'b1, 1'b0, 16'h1291, 8'h00, 8'hC3},
        {2'd1, 1'b0, 1'b0, 16'h0005, 8'h00, 8'h39},
        {2'd0, 1'b0, 1'b1, 16'hF00D, 8'h00, 8'h00},
        {2'd1, 1'b1, 1'b0, 16'h00A0, 8'h00, 8'h9C}
    };

    xbus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_narrow(req_narrow), .req_addr(req_addr), .req_wdata(req_wdata),
        .int_rom_en(int_rom_en), .req_ready(req_ready), .rdata(rdata),
        .done(done), .int_hit(int_hit), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .hi_out(hi_out), .hi_oe(hi_oe), .ale(ale),
        .code_rd_n(code_rd_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] code_fn(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h96;
    endfunction

    // external latch and memories
    always @(negedge ale) lat_lo = ad_out;
    assign ad_in = !code_rd_n ? code_fn({hi_out, lat_lo}) :
                   (!rd_n ? dmem[lat_lo] : 8'hEE);

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ale) begin
                ale_cnt++;
                ale_cyc_prev = ale_cyc_last;
                ale_cyc_last = cyc;
            end
            if (hi_oe) begin
                hi_seen = 1'b1;
                hi_val  = hi_out;
            end
            if ((!code_rd_n || !rd_n) && ad_oe) bad_float++;
            if ($countones({~code_rd_n, ~rd_n, ~wr_n}) > 1) bad_excl++;
            if (!code_rd_n || !rd_n || !wr_n) last_low = cyc;
            if (!wr_n) begin
                wr_seen = ad_out;
                dmem[lat_lo] = ad_out;
            end
            if (done) done_cyc = cyc;
            if (int_hit) int_cnt++;
        end
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        ale_cnt = 0; hi_seen = 1'b0; hi_val = 8'h0; last_low = 0;
        done_cyc = 0; int_cnt = 0; wr_seen = 8'h0;
    endtask

    task automatic access(input logic [1:0] op, input logic narrow, input logic rom,
                          input logic [15:0] addr, input logic [7:0] wdata);
        clear_mon();
        req_op = op; req_narrow = narrow; int_rom_en = rom;
        req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (done || int_hit) break;
            tick();
        end
        for (int k = 0; k < 3; k++) tick();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i) ^ 8'h3C;
        clear_mon();
        ale_cyc_last = 0; ale_cyc_prev = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(!ale && code_rd_n && rd_n && wr_n, "R1 strobes idle",
              {ale, code_rd_n, rd_n, wr_n}, 4'b0111);
        check(!ad_oe && !hi_oe && !done && !int_hit && req_ready, "R1 ports released",
              {ad_oe, hi_oe, done, int_hit, req_ready}, 5'b00001);

        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            logic [1:0]  op;
            logic [15:0] a;
            bit          internal;
            v  = VECS[i];
            op = v[35:34];
            a  = v[31:16];
            access(op, v[33], v[32], a, v[15:8]);
            internal = (op == 2'd0) && v[32] && (a < 16'h1000);
            if (internal) begin
                check(int_cnt == 1 && ale_cnt == 0 && !hi_seen, "R11 internal fetch",
                      {int_cnt[7:0], ale_cnt[7:0]}, 16'h0100);
            end else begin
                check(ale_cnt == 1 && lat_lo == a[7:0], "R2 address phase",
                      {ale_cnt[7:0], lat_lo}, {8'd1, a[7:0]});
                check(int_cnt == 0, "R11 external path", int_cnt, 0);
                if (op != 2'd0 && v[33])
                    check(!hi_seen, "R4 high port free", hi_seen, 0);
                else
                    check(hi_seen && hi_val == a[15:8], "R3 high address",
                          hi_val, a[15:8]);
                check(done_cyc - last_low == 2, "R9 done timing",
                      done_cyc - last_low, 2);
                if (op == 2'd0)
                    check(rdata == code_fn(a), "R5 code byte", rdata, code_fn(a));
                else if (op == 2'd1)
                    check(rdata == v[7:0], "R6 data byte", rdata, v[7:0]);
                else
                    check(wr_seen == v[15:8] && dmem[a[7:0]] == v[15:8], "R7 write byte",
                          wr_seen, v[15:8]);
            end
        end

        // R10 back-to-back reads: ale every 6 clocks
        clear_mon();
        req_op = 2'd1; req_narrow = 1'b0; req_addr = 16'h2040; req_valid = 1'b1;
        for (int k = 0; k < 40; k++) begin
            tick();
            if (ale_cnt >= 3) break;
        end
        req_valid = 1'b0;
        check(ale_cnt == 3 && ale_cyc_last - ale_cyc_prev == 6, "R10 ale period",
              ale_cyc_last - ale_cyc_prev, 6);
        for (int k = 0; k < 10; k++) tick();
        check(req_ready, "R10 ready in idle", req_ready, 1);

        // R1 reset while the write strobe is low
        clear_mon();
        req_op = 2'd2; req_narrow = 1'b1; req_addr = 16'h0033; req_wdata = 8'h5A;
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (!wr_n) break;
            tick();
        end
        check(!wr_n, "R7 write strobe reached", wr_n, 0);
        rst_n = 1'b0;
        #1;
        check(wr_n && !ad_oe && !ale && !hi_oe && !done, "R1 reset mid-access",
              {wr_n, ad_oe, ale, hi_oe, done}, 5'b10000);
        tick();
        rst_n = 1'b1;
        tick();
        check(req_ready && wr_n, "R1 idle after reset", {req_ready, wr_n}, 2'b11);

        check(bad_float == 0, "R8 port floated on reads", bad_float, 0);
        check(bad_excl == 0, "R8 strobe exclusion", bad_excl, 0);
        summary();
    end
endmodule